// File: doc/BRIEF.md
# 32-bit Combinational ALU With Zero Flag

This block is the arithmetic and logic unit of a single-cycle 32-bit datapath. It takes two operand words and a 4-bit operation code. It returns one result word and a flag that reports an all-zero result. The block holds no state, so the result follows its inputs within the same cycle. Branch logic can therefore use the flag in the cycle where the operands arrive.

Three units compute every candidate result at the same time: a logic unit, an add/subtract/compare unit and a shift unit. The operation code then picks one of them through a case-based selector. Overflow is not detected. The signed and unsigned forms of add and subtract therefore return identical words. The signed less-than compare inverts the top bit of each operand and then compares the two as unsigned numbers.

Top module: `alu_core`

## Requirements
- R1: The logic codes return a bitwise result of the two operands: 0000 gives A AND B, 0001 gives A OR B, 1010 gives A XOR B and 1100 gives NOT(A OR B).
- R2: Codes 0010 and 1000 both return A + B modulo 2^32, with no overflow indication.
- R3: Codes 0110 and 1001 both return A - B modulo 2^32, with no overflow indication.
- R4: Code 0111 returns 1 in bit 0 when A is less than B as two's complement numbers, and 0 otherwise. Bits 31 to 1 are always zero.
- R5: Code 1011 returns 1 in bit 0 when A is less than B as unsigned numbers, and 0 otherwise. Bits 31 to 1 are always zero.
- R6: Code 0011 returns B shifted left and code 0100 returns B shifted right with zero fill. The shift distance is A[4:0], and A[31:5] has no effect.
- R7: Code 1101 returns B shifted right by A[4:0], and each vacated bit is a copy of B[31].
- R8: Code 1110 returns B[15:0] in bits 31 to 16 and zero in bits 15 to 0.
- R9: The unused codes 0101 and 1111 return a result of zero.
- R10: The zero output is 1 exactly when all 32 result bits are 0.
- R11: The block holds no state. A change on any input shows at the result and the zero output in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand, and the shift distance in bits 4:0 |
| opnd_b | input | 32 | Second operand, and the value that gets shifted |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Selected result word |
| zero | output | 1 | High when result is all zeros |

## Verification
The block stores nothing, so a fault in the selector or in one of the units shows at the result port as soon as the inputs settle. It is visible in the very cycle that drives the affected code. A wrong case arm surfaces only when its own operation code is applied. A wrong compare or shift-fill shows only for particular operands: mixed sign bits for the signed compare, a set B[31] for the arithmetic shift, and shift distances of 32 or more in A. The stimulus therefore steers random operands toward those conditions. A flag decoupled from the result shows whenever an input gives an all-zero result, such as equal operands under subtract or the unused codes.

// File: rtl/alu_pkg.sv
// Package: shared operation codes for the ALU.
// Assumes a 4-bit select. Codes not listed here are treated as unused.
package alu_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        OP_AND  = 4'b0000,
        OP_OR   = 4'b0001,
        OP_ADD  = 4'b0010,
        OP_SLL  = 4'b0011,
        OP_SRL  = 4'b0100,
        OP_SUB  = 4'b0110,
        OP_SLT  = 4'b0111,
        OP_ADDU = 4'b1000,
        OP_SUBU = 4'b1001,
        OP_XOR  = 4'b1010,
        OP_SLTU = 4'b1011,
        OP_NOR  = 4'b1100,
        OP_SRA  = 4'b1101,
        OP_LUI  = 4'b1110
    } alu_op_e;

endpackage

// File: rtl/alu_logic_unit.sv
// Module: alu_logic_unit
// Produces all four bitwise results of the two operands at once.
// Assumes nothing about operand values. Purely combinational.
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] and_r,
    output logic [WIDTH-1:0] or_r,
    output logic [WIDTH-1:0] xor_r,
    output logic [WIDTH-1:0] nor_r
);

    // Bitwise functions of the two operands.
    always_comb begin
        and_r = a & b;
        or_r  = a | b;
        xor_r = a ^ b;
        nor_r = ~(a | b);
    end

    // Consistency checks across the logic results.
    always_comb begin
        AST_OR_SPLIT: assert ((and_r | xor_r) == or_r)
            else $error("or result is not the union of and and xor"); // R1
        AST_NOR_DISJOINT: assert ((nor_r & or_r) == '0)
            else $error("nor and or overlap"); // R1
    end

endmodule

// File: rtl/alu_arith_unit.sv
// Module: alu_arith_unit
// Sum, difference and the signed and unsigned less-than flags.
// Assumes WIDTH >= 2 and no overflow detection. Wraps modulo 2^WIDTH.
module alu_arith_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum_r,
    output logic [WIDTH-1:0] diff_r,
    output logic [WIDTH-1:0] slt_r,
    output logic [WIDTH-1:0] sltu_r
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_flip;
    logic [WIDTH-1:0] b_flip;
    logic             lt_signed;
    logic             lt_unsigned;

    // Wrapping add and subtract shared by the signed and unsigned codes.
    always_comb begin
        sum_r  = a + b;
        diff_r = a - b;
    end

    // Signed compare: invert the sign bits, then compare unsigned.
    always_comb begin
        a_flip      = {~a[MSB], a[MSB-1:0]};
        b_flip      = {~b[MSB], b[MSB-1:0]};
        lt_signed   = (a_flip < b_flip);
        lt_unsigned = (a < b);
    end

    // Place the one-bit flags in bit 0 with the upper bits cleared.
    always_comb begin
        slt_r  = {{(WIDTH-1){1'b0}}, lt_signed};
        sltu_r = {{(WIDTH-1){1'b0}}, lt_unsigned};
    end

    // Checks relating arithmetic results to their operands.
    always_comb begin
        AST_SUB_UNDO: assert ((diff_r + b) == a)
            else $error("difference plus b does not give a"); // R3
        AST_ADD_UNDO: assert ((sum_r - b) == a)
            else $error("sum minus b does not give a"); // R2
        AST_SLT_MIXED: assert ((a[MSB] == b[MSB]) || (slt_r[0] == a[MSB]))
            else $error("signed compare wrong for mixed signs"); // R4
        AST_LT_EQUAL: assert ((a != b) || ((slt_r | sltu_r) == '0))
            else $error("less-than set for equal operands"); // R5
    end

endmodule

// File: rtl/alu_shift_unit.sv
// Module: alu_shift_unit
// Logical left and right shifts, the arithmetic right shift and upper-half load.
// Assumes WIDTH is a power of two. The shift distance is the low log2(WIDTH) bits.
module alu_shift_unit #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [WIDTH-1:0]   sll_r,
    output logic [WIDTH-1:0]   srl_r,
    output logic [WIDTH-1:0]   sra_r,
    output logic [WIDTH-1:0]   lui_r
);

    localparam int HALF = WIDTH / 2;

    // Barrel shifts of b by the shift distance.
    always_comb begin
        sll_r = b << shamt;
        srl_r = b >> shamt;
        sra_r = WIDTH'($signed(b) >>> shamt);
    end

    // Move the low half of b into the upper half.
    always_comb begin
        lui_r = {b[HALF-1:0], {HALF{1'b0}}};
    end

    // Checks on shift fill behaviour.
    always_comb begin
        AST_SRA_POS: assert (b[WIDTH-1] || (sra_r == srl_r))
            else $error("arithmetic shift differs for non-negative b"); // R7
        AST_SRA_TOP: assert (sra_r[WIDTH-1] == b[WIDTH-1])
            else $error("arithmetic shift lost sign"); // R7
        AST_LUI_LOW: assert (lui_r[HALF-1:0] == '0)
            else $error("upper load left low bits set"); // R8
    end

endmodule

// File: rtl/alu_core.sv
// Module: alu_core
// Top of the ALU. Runs the logic, arithmetic and shift units in parallel,
// selects one result with a case on the operation code, and flags zero.
// Assumes no clock and no reset. Unused codes give zero, and every arm assigns.
module alu_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         opnd_a,
    input  logic [WIDTH-1:0]         opnd_b,
    input  logic [alu_pkg::SEL_W-1:0] op_sel,
    output logic [WIDTH-1:0]         result,
    output logic                     zero
);

    import alu_pkg::*;

    localparam int SHAMT_W = $clog2(WIDTH);

    logic [WIDTH-1:0] and_r, or_r, xor_r, nor_r;
    logic [WIDTH-1:0] sum_r, diff_r, slt_r, sltu_r;
    logic [WIDTH-1:0] sll_r, srl_r, sra_r, lui_r;
    logic             code_unused;

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a     (opnd_a),
        .b     (opnd_b),
        .and_r (and_r),
        .or_r  (or_r),
        .xor_r (xor_r),
        .nor_r (nor_r)
    );

    alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .sum_r  (sum_r),
        .diff_r (diff_r),
        .slt_r  (slt_r),
        .sltu_r (sltu_r)
    );

    alu_shift_unit #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
        .b     (opnd_b),
        .shamt (opnd_a[SHAMT_W-1:0]),
        .sll_r (sll_r),
        .srl_r (srl_r),
        .sra_r (sra_r),
        .lui_r (lui_r)
    );

    // Result selector: each code picks one unit output, unused codes give zero.
    always_comb begin
        code_unused = 1'b0;
        case (op_sel)
            OP_AND:           result = and_r;
            OP_OR:            result = or_r;
            OP_XOR:           result = xor_r;
            OP_NOR:           result = nor_r;
            OP_ADD, OP_ADDU:  result = sum_r;
            OP_SUB, OP_SUBU:  result = diff_r;
            OP_SLT:           result = slt_r;
            OP_SLTU:          result = sltu_r;
            OP_SLL:           result = sll_r;
            OP_SRL:           result = srl_r;
            OP_SRA:           result = sra_r;
            OP_LUI:           result = lui_r;
            default: begin
                result      = '0;
                code_unused = 1'b1;
            end
        endcase
    end

    // Zero flag from a reduction over the selected result.
    assign zero = ~|result;

    // Port-level checks on the selector and the flag.
    always_comb begin
        AST_UNUSED_ZERO: assert (!code_unused || zero)
            else $error("unused code did not give a zero result"); // R9
        AST_CMP_NARROW: assert (!((op_sel == OP_SLT) || (op_sel == OP_SLTU)) || (result[WIDTH-1:1] == '0))
            else $error("compare result has upper bits set"); // R4
        AST_FLAG_LOW: assert (!zero || (result[0] == 1'b0))
            else $error("zero flag set with bit 0 high"); // R10
    end

endmodule

// File: tb/alu_core_bench.sv
// Bench for alu_core: directed corner cases plus seeded random operations,
// compared against a reference model written from the requirements.
module alu_core_bench;

    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    alu_core #(.WIDTH(32)) u_alu_core (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .op_sel (op_sel),
        .result (result),
        .zero   (zero)
    );

    // Reference model written from the requirement list.
    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'b0000: return a & b;
            4'b0001: return a | b;
            4'b1010: return a ^ b;
            4'b1100: return ~(a | b);
            4'b0010, 4'b1000: return a + b;
            4'b0110, 4'b1001: return a - b;
            4'b0111: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'b1011: return (a < b) ? 32'd1 : 32'd0;
            4'b0011: return b << a[4:0];
            4'b0100: return b >> a[4:0];
            4'b1101: return 32'($signed(b) >>> a[4:0]);
            4'b1110: return {b[15:0], 16'h0000};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'b0000, 4'b0001, 4'b1010, 4'b1100: return "R1";
            4'b0010, 4'b1000: return "R2";
            4'b0110, 4'b1001: return "R3";
            4'b0111: return "R4";
            4'b1011: return "R5";
            4'b0011, 4'b0100: return "R6";
            4'b1101: return "R7";
            4'b1110: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] exp_r);
        total++;
        if (result !== exp_r) begin
            bad++;
            $display("FAIL %s result actual=%h expected=%h", tag, result, exp_r);
        end
        total++;
        if (zero !== (exp_r == 32'd0)) begin
            bad++;
            $display("FAIL R10 (%s) zero actual=%0b expected=%0b", tag, zero, (exp_r == 32'd0));
        end
    endtask

    // Drive on the falling edge, sample 1 ns later, away from the rising edge.
    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b;
        #1;
        compare(req_of(op), model(op, a, b));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++; bad++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] ra, rb;
        logic [3:0]  rop;
        void'($urandom(32'd651));
        // Idle state: all inputs zero, AND code.
        @(negedge clk); #1;
        compare("R1 idle", 32'd0);
        // R1 logic codes
        apply(4'b0000, 32'hF0F0_1234, 32'hFF00_FF00);
        apply(4'b0001, 32'hF0F0_1234, 32'h0F0F_0000);
        apply(4'b1010, 32'hAAAA_5555, 32'hAAAA_5555);
        apply(4'b1100, 32'h0000_0000, 32'h0000_0000);
        // R2 wrapping add, both codes
        apply(4'b0010, 32'h7FFF_FFFF, 32'h0000_0001);
        apply(4'b1000, 32'hFFFF_FFFF, 32'h0000_0001);
        // R3 wrapping subtract, both codes
        apply(4'b0110, 32'h0000_0005, 32'h0000_0005);
        apply(4'b1001, 32'h0000_0000, 32'h0000_0001);
        // R4 signed compare
        apply(4'b0111, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(4'b0111, 32'h0000_0001, 32'hFFFF_FFFF);
        apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
        // R5 unsigned compare
        apply(4'b1011, 32'hFFFF_FFFF, 32'h0000_0001);
        apply(4'b1011, 32'h0000_0001, 32'hFFFF_FFFF);
        // R6 shifts, upper distance bits ignored
        apply(4'b0011, 32'h0000_0021, 32'h8000_0001);
        apply(4'b0100, 32'hFFFF_FFE4, 32'h8000_0000);
        // R7 arithmetic shift
        apply(4'b1101, 32'h0000_001F, 32'h8000_0000);
        apply(4'b1101, 32'h0000_0004, 32'h7000_0000);
        // R8 upper-half load
        apply(4'b1110, 32'h1234_5678, 32'hDEAD_BEEF);
        // R9 unused codes
        apply(4'b0101, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(4'b1111, 32'h1234_5678, 32'h9ABC_DEF0);
        // R11: two input changes inside one clock period, each seen at once
        @(negedge clk);
        op_sel = 4'b0010; opnd_a = 32'd10; opnd_b = 32'd20; #0.5;
        compare("R11 first", 32'd30);
        opnd_b = 32'hFFFF_FFF6; #0.5;
        compare("R11 second", 32'd0);
        // Seeded random mix steered toward corner operands
        for (int i = 0; i < 3000; i++) begin
            rop = 4'($urandom);
            ra  = $urandom;
            rb  = $urandom;
            case ($urandom % 6)
                0: rb = ra;
                1: ra = ra & 32'h0000_003F;
                2: rb = rb | 32'h8000_0000;
                3: ra = {~rb[31], ra[30:0]};
                default: ;
            endcase
            apply(rop, ra, rb);
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule